// File: doc/BRIEF.md
# Non-Pipelined External Bus Cycle Controller

This block is the bus master for a processor-style external bus with a 16-bit data path and a 24-bit byte address space. An internal requester presents one read or write at a time, with a word address, byte enables and write data. The controller runs each transfer as a non-pipelined bus cycle and reports completion with a one-clock done pulse. Read data comes back with that pulse.

The block runs from a double-rate clock. Each bus state lasts two clocks: phase one, then phase two. A phase toggle that starts at reset keeps the two phases aligned. The bus is always in one of four states: idle, first state of a cycle, later state of a cycle, or hold. A cycle opens with one first state, in which the address, byte enables and read/write definition are driven and the active-low address strobe is asserted. It then runs one or more later states. At the end of each later state the controller samples the active-low ready input. Ready inactive adds a wait state; ready active ends the cycle.

An external master can take the bus through a hold request. While in hold, the controller floats every output it normally drives and raises hold acknowledge. The controller also watches the active-low next-address input. Address pipelining is not supported, so a next-address request seen in any later state other than the last one sets a sticky protocol-error flag, and the cycle carries on unchanged.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While synchronous reset is asserted and right after it is released, the bus is idle: strobe high, hold acknowledge low, data enable low, done low and the protocol-error flag low.
- R2: A new cycle drives the address, byte enables and read/write definition (bus_wr, 1 = write), all valid, in the same clock that the strobe goes low. The strobe stays low for exactly two clocks, the first bus state of the cycle.
- R3: A zero-wait cycle takes two bus states (four clocks). Two such requests presented back to back are accepted exactly four clocks apart, with no idle state between them.
- R4: Each later state in which ready is still high at its second clock is followed by another later state. This adds two clocks per wait state. Address, byte enables and definition stay unchanged and the strobe stays high throughout.
- R5: In a read the data enable stays low. The value on bus_din at the acknowledging edge appears on rsp_rdata, together with a done pulse lasting exactly one clock, in the clock that follows.
- R6: In a write the data enable is high from the second clock of the first state until the first clock of the state after acknowledgement, and bus_dout carries the requested write data.
- R7: A hold request is acted on only from idle or at the end of an acknowledged cycle. The hold state raises hold_ack, drops bus_ctl_oe and accepts no request. The controller leaves hold for idle at the end of the first bus state in which the hold request is seen low.
- R8: Next-address sampled low at the end of a later state that is not the final one sets proto_err, and proto_err stays set until reset. Next-address low in the final later state has no effect. The cycle's timing and data are unchanged in both cases.
- R9: req_accept is high only in the second clock of an idle state or of an acknowledging later state, with no hold pending. The request fields are captured on that edge, and the next clock begins a first state.
- R10: bus_be_n is the bitwise inverse of the requested byte enables: bit 0 selects the low byte and bit 1 selects the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock, two clocks per bus state |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address (byte address bits 23:1) |
| req_be | input | 2 | Byte enables, active high |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | Request captured on this edge |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| bus_addr | output | 23 | External word address |
| bus_be_n | output | 2 | External byte enables, active low |
| bus_wr | output | 1 | Cycle definition, 1 = write |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_ctl_oe | output | 1 | Enable for address, strobe and definition drivers |
| bus_dout | output | 16 | Data driven toward the bus |
| bus_dout_oe | output | 1 | Data driver enable |
| bus_din | input | 16 | Data received from the bus |
| bus_rdy_n | input | 1 | Ready, active low |
| bus_na_n | input | 1 | Next-address request, active low |
| hold_req | input | 1 | Hold request from another master |
| hold_ack | output | 1 | Hold acknowledge |
| proto_err | output | 1 | Sticky flag: pipelining requested in a non-final later state |

## Verification
The assertions assume that a requester keeps req_valid and its fields steady from assertion until req_accept. They also assume the bus device drives ready and next-address steadily across both clocks of a later state. This matters because the controller looks at those inputs only on the phase-two edge, so the checks on stable control and data enable rely on sampling at that point alone. The bench device model changes ready, next-address and bus_din only in the first clock of each later state, and keeps ready high everywhere else. The driver raises hold only while idle, or during a cycle that is already under way.

// File: rtl/bus_pkg.sv
package bus_pkg;

    // Bus state encoding shared by the sequencer, datapath and checker.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2,
        ST_HOLD = 2'd3
    } bus_state_e;

endpackage

// File: rtl/bus_phase_gen.sv
// Two-phase tracker: each bus state spans two clocks of the double-rate clock.
module bus_phase_gen (
    input  logic clk2,
    input  logic rst,
    output logic ph2
);

    typedef struct packed {
        logic ph2;
    } phase_reg_t;

    phase_reg_t ph_d, ph_q;

    always_comb begin
        ph_d     = ph_q;
        ph_d.ph2 = ~ph_q.ph2;
        if (rst) begin
            ph_d.ph2 = 1'b0;
        end
    end

    always_ff @(posedge clk2) begin
        ph_q <= ph_d;
    end

    assign ph2 = ph_q.ph2;

endmodule

// File: rtl/bus_seq_fsm.sv
// Bus state sequencer: idle, first state, later state, hold.
module bus_seq_fsm import bus_pkg::*; (
    input  logic       clk2,
    input  logic       rst,
    input  logic       ph2,
    input  logic       req_valid,
    input  logic       hold_req,
    input  logic       rdy_n,
    input  logic       na_n,
    output bus_state_e st,
    output logic       accept,
    output logic       ack,
    output logic       err
);

    typedef struct packed {
        bus_state_e st;
        logic       err;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     accept_d;
    logic     ack_d;

    always_comb begin
        seq_d    = seq_q;
        accept_d = 1'b0;
        ack_d    = 1'b0;
        if (ph2) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (hold_req) begin
                        seq_d.st = ST_HOLD;
                    end else if (req_valid) begin
                        seq_d.st = ST_T1;
                        accept_d = 1'b1;
                    end
                end
                ST_T1: begin
                    seq_d.st = ST_T2;
                end
                ST_T2: begin
                    if (!rdy_n) begin
                        ack_d = 1'b1;
                        if (hold_req) begin
                            seq_d.st = ST_HOLD;
                        end else if (req_valid) begin
                            seq_d.st = ST_T1;
                            accept_d = 1'b1;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end else if (!na_n) begin
                        // pipelining requested before the last later state
                        seq_d.err = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!hold_req) begin
                        seq_d.st = ST_IDLE;
                    end
                end
                default: begin
                    seq_d.st = ST_IDLE;
                end
            endcase
        end
        if (rst) begin
            seq_d.st  = ST_IDLE;
            seq_d.err = 1'b0;
            accept_d  = 1'b0;
            ack_d     = 1'b0;
        end
    end

    always_ff @(posedge clk2) begin
        seq_q <= seq_d;
    end

    assign st     = seq_q.st;
    assign err    = seq_q.err;
    assign accept = accept_d;
    assign ack    = ack_d;

endmodule

// File: rtl/bus_dpath.sv
// Request capture, bus drive enables and read return path.
module bus_dpath import bus_pkg::*; #(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 16,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic              ph2,
    input  bus_state_e        st,
    input  logic              accept,
    input  logic              ack,
    input  logic              req_write,
    input  logic [ADDR_W-1:1] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:1] bus_addr,
    output logic [BE_W-1:0]   bus_be_n,
    output logic              bus_wr,
    output logic              bus_ads_n,
    output logic              bus_ctl_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_oe,
    output logic              hold_ack,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [ADDR_W-1:1] addr;
        logic [BE_W-1:0]   be_n;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              tail;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } dp_reg_t;

    dp_reg_t dp_d, dp_q;

    always_comb begin
        dp_d      = dp_q;
        dp_d.done = ack;
        dp_d.tail = ack & dp_q.wr;
        if (ack && !dp_q.wr) begin
            dp_d.rdata = bus_din;
        end
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.be_n  = ~req_be;
            dp_d.wr    = req_write;
            dp_d.wdata = req_wdata;
        end
        if (rst) begin
            dp_d.addr  = '0;
            dp_d.be_n  = '1;
            dp_d.wr    = 1'b0;
            dp_d.wdata = '0;
            dp_d.tail  = 1'b0;
            dp_d.done  = 1'b0;
            dp_d.rdata = '0;
        end
    end

    always_ff @(posedge clk2) begin
        dp_q <= dp_d;
    end

    logic t1_late;
    assign t1_late = (st == ST_T1) & ph2;

    assign bus_addr    = dp_q.addr;
    assign bus_be_n    = dp_q.be_n;
    assign bus_wr      = dp_q.wr;
    assign bus_ads_n   = (st != ST_T1);
    assign bus_ctl_oe  = (st != ST_HOLD);
    assign bus_dout    = dp_q.wdata;
    assign bus_dout_oe = (dp_q.wr & (t1_late | (st == ST_T2))) | dp_q.tail;
    assign hold_ack    = (st == ST_HOLD);
    assign rsp_done    = dp_q.done;
    assign rsp_rdata   = dp_q.rdata;

endmodule

// File: rtl/bus_cycle_ctrl.sv
// Top: non-pipelined external bus cycle controller.
module bus_cycle_ctrl import bus_pkg::*; #(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 16,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:1] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:1] bus_addr,
    output logic [BE_W-1:0]   bus_be_n,
    output logic              bus_wr,
    output logic              bus_ads_n,
    output logic              bus_ctl_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_oe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy_n,
    input  logic              bus_na_n,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic              proto_err
);

    logic       ph2;
    bus_state_e st_q;
    logic       accept;
    logic       ack;

    bus_phase_gen u_phase (
        .clk2 (clk2),
        .rst  (rst),
        .ph2  (ph2)
    );

    bus_seq_fsm u_seq (
        .clk2      (clk2),
        .rst       (rst),
        .ph2       (ph2),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .rdy_n     (bus_rdy_n),
        .na_n      (bus_na_n),
        .st        (st_q),
        .accept    (accept),
        .ack       (ack),
        .err       (proto_err)
    );

    bus_dpath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dpath (
        .clk2        (clk2),
        .rst         (rst),
        .ph2         (ph2),
        .st          (st_q),
        .accept      (accept),
        .ack         (ack),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .bus_din     (bus_din),
        .bus_addr    (bus_addr),
        .bus_be_n    (bus_be_n),
        .bus_wr      (bus_wr),
        .bus_ads_n   (bus_ads_n),
        .bus_ctl_oe  (bus_ctl_oe),
        .bus_dout    (bus_dout),
        .bus_dout_oe (bus_dout_oe),
        .hold_ack    (hold_ack),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata)
    );

    assign req_accept = accept;

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
// Protocol checker bound to the controller.
module bus_cycle_ctrl_chk import bus_pkg::*; #(
    parameter int ADDR_W = 24,
    parameter int BE_W   = 2
) (
    input logic              clk2,
    input logic              rst,
    input bus_state_e        st,
    input logic              req_accept,
    input logic              rsp_done,
    input logic [ADDR_W-1:1] bus_addr,
    input logic [BE_W-1:0]   bus_be_n,
    input logic              bus_wr,
    input logic              bus_ads_n,
    input logic              bus_ctl_oe,
    input logic              bus_dout_oe,
    input logic              hold_ack,
    input logic              proto_err
);

    // R2
    ads_hold_chk: assert property (@(posedge clk2) disable iff (rst)
        $fell(bus_ads_n) |=> !bus_ads_n);

    // R2
    ads_width_chk: assert property (@(posedge clk2) disable iff (rst)
        (!bus_ads_n && $past(!bus_ads_n)) |=> bus_ads_n);

    // R9
    accept_start_chk: assert property (@(posedge clk2) disable iff (rst)
        req_accept |=> $fell(bus_ads_n));

    // R4
    ctl_stable_chk: assert property (@(posedge clk2) disable iff (rst)
        (st == ST_T2) |-> ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wr)));

    // R5
    read_float_chk: assert property (@(posedge clk2) disable iff (rst)
        (st == ST_T2 && !bus_wr) |-> !bus_dout_oe);

    // R6
    write_drive_chk: assert property (@(posedge clk2) disable iff (rst)
        (st == ST_T2 && bus_wr) |-> bus_dout_oe);

    // R5
    done_pulse_chk: assert property (@(posedge clk2) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R7
    hold_float_chk: assert property (@(posedge clk2) disable iff (rst)
        hold_ack |-> (!bus_ctl_oe && !req_accept));

    // R8
    err_sticky_chk: assert property (@(posedge clk2) disable iff (rst)
        proto_err |=> proto_err);

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W)
) u_chk (
    .clk2        (clk2),
    .rst         (rst),
    .st          (st_q),
    .req_accept  (req_accept),
    .rsp_done    (rsp_done),
    .bus_addr    (bus_addr),
    .bus_be_n    (bus_be_n),
    .bus_wr      (bus_wr),
    .bus_ads_n   (bus_ads_n),
    .bus_ctl_oe  (bus_ctl_oe),
    .bus_dout_oe (bus_dout_oe),
    .hold_ack    (hold_ack),
    .proto_err   (proto_err)
);

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;

    localparam int AW = 24;
    localparam int DW = 16;

    typedef struct {
        bit          wr;
        logic [22:0] addr;
        logic [1:0]  be;
        logic [15:0] wdata;
        int          waits;
        int          na_mode; // 0 none, 1 early (error), 2 final (harmless)
    } item_t;

    logic          clk2 = 1'b0;
    logic          rst;
    logic          req_valid, req_write;
    logic [AW-1:1] req_addr;
    logic [1:0]    req_be;
    logic [DW-1:0] req_wdata;
    logic          req_accept, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:1] bus_addr;
    logic [1:0]    bus_be_n;
    logic          bus_wr, bus_ads_n, bus_ctl_oe, bus_dout_oe;
    logic [DW-1:0] bus_dout, bus_din;
    logic          bus_rdy_n, bus_na_n, hold_req, hold_ack, proto_err;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    finished = 0;
    bit    dev_busy = 0;
    int    acc_cyc;
    item_t exp_q[$];

    always #4 clk2 = ~clk2;
    always @(posedge clk2) cyc <= cyc + 1;

    bus_cycle_ctrl u_bus_cycle_ctrl (
        .clk2(clk2), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_accept(req_accept), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wr(bus_wr),
        .bus_ads_n(bus_ads_n), .bus_ctl_oe(bus_ctl_oe), .bus_dout(bus_dout),
        .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n),
        .bus_na_n(bus_na_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .proto_err(proto_err)
    );

    function automatic logic [15:0] pattern(logic [22:0] a);
        return a[15:0] ^ 16'h5AC3;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Driver: push the expected item, present the request, wait for capture.
    task automatic issue(bit wr, logic [22:0] a, logic [1:0] be, logic [15:0] wd,
                         int waits, int na_mode);
        item_t it;
        it.wr = wr; it.addr = a; it.be = be; it.wdata = wd;
        it.waits = waits; it.na_mode = na_mode;
        exp_q.push_back(it);
        req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        req_valid = 1'b1;
        #1;
        while (!req_accept) begin
            @(negedge clk2);
            #1;
        end
        acc_cyc = cyc;
        @(negedge clk2);
        req_valid = 1'b0;
    endtask

    // Monitor / bus device: starts at the first clock of a cycle.
    task automatic do_cycle();
        item_t it;
        logic [15:0] rd;
        dev_busy = 1;
        if (exp_q.size() == 0) begin
            check(0, "R2 unexpected bus cycle", 0, 1);
            @(negedge clk2);
            dev_busy = 0;
            return;
        end
        it = exp_q.pop_front();
        rd = pattern(it.addr);
        check(bus_addr == it.addr, "R2 address valid with strobe", bus_addr, it.addr);
        check(bus_wr == it.wr, "R2 cycle definition", bus_wr, it.wr);
        check(bus_be_n == ~it.be, "R10 byte enables inverted", bus_be_n, ~it.be);
        @(negedge clk2);
        check(!bus_ads_n, "R2 strobe held second clock", bus_ads_n, 0);
        check(bus_dout_oe == it.wr, it.wr ? "R6 drive from phase two" : "R5 read floats",
              bus_dout_oe, it.wr);
        for (int i = 0; i <= it.waits; i++) begin
            @(negedge clk2);
            bus_rdy_n = (i == it.waits) ? 1'b0 : 1'b1;
            bus_na_n  = ((it.na_mode == 1 && i == 0 && it.waits > 0) ||
                         (it.na_mode == 2 && i == it.waits)) ? 1'b0 : 1'b1;
            bus_din   = rd;
            check(bus_ads_n, "R4 strobe high in later state", bus_ads_n, 1);
            check(bus_addr == it.addr, "R4 address held", bus_addr, it.addr);
            @(negedge clk2);
            if (it.wr)
                check(bus_dout_oe && bus_dout == it.wdata, "R6 write data",
                      {bus_dout_oe, bus_dout}, {1'b1, it.wdata});
            else
                check(!bus_dout_oe, "R5 read floats", bus_dout_oe, 0);
        end
        @(negedge clk2);
        bus_rdy_n = 1'b1;
        bus_na_n  = 1'b1;
        bus_din   = '0;
        check(rsp_done, "R5 done pulse", rsp_done, 1);
        if (!it.wr) check(rsp_rdata == rd, "R5 read data", rsp_rdata, rd);
        check(bus_dout_oe == it.wr, "R6 drive tail one clock", bus_dout_oe, it.wr);
        dev_busy = 0;
    endtask

    initial begin
        forever begin
            if (bus_ads_n === 1'b0) do_cycle();
            else @(negedge clk2);
        end
    end

    task automatic drain();
        do @(negedge clk2); while (exp_q.size() != 0 || dev_busy);
        repeat (4) @(negedge clk2);
    endtask

    initial begin
        repeat (50000) @(posedge clk2);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int c1, c2, n;
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_be = '0;
        req_wdata = '0; bus_din = '0; bus_rdy_n = 1; bus_na_n = 1; hold_req = 0;
        repeat (4) @(negedge clk2);
        check(bus_ads_n && !hold_ack && !bus_dout_oe && !rsp_done && !proto_err,
              "R1 reset state", {bus_ads_n, hold_ack, bus_dout_oe, rsp_done, proto_err}, 5'b10000);
        rst = 0;
        @(negedge clk2);
        check(bus_ads_n && !hold_ack && !proto_err, "R1 idle after reset",
              {bus_ads_n, hold_ack, proto_err}, 3'b100);

        // main function, several patterns
        issue(0, 23'h001234, 2'b11, 16'h0000, 0, 0);
        issue(1, 23'h00ABCD, 2'b01, 16'hBEEF, 0, 0);
        issue(0, 23'h7F0F0F, 2'b10, 16'h0000, 2, 2);
        issue(1, 23'h400001, 2'b10, 16'h1357, 3, 0);
        // R3 back to back zero-wait
        issue(0, 23'h000100, 2'b11, 16'h0000, 0, 0);
        c1 = acc_cyc;
        issue(0, 23'h000102, 2'b11, 16'h0000, 0, 0);
        c2 = acc_cyc;
        check(c2 - c1 == 4, "R3 zero-wait accept spacing", c2 - c1, 4);
        // R4 one wait state adds two clocks
        issue(1, 23'h000200, 2'b11, 16'hA5A5, 1, 0);
        c1 = acc_cyc;
        issue(1, 23'h000202, 2'b01, 16'h5A5A, 0, 0);
        c2 = acc_cyc;
        check(c2 - c1 == 6, "R4 one wait spacing", c2 - c1, 6);
        drain();
        check(!proto_err, "R8 next-address in final state ignored", proto_err, 0);

        // R7 hold from idle
        hold_req = 1;
        repeat (4) @(negedge clk2);
        check(hold_ack && !bus_ctl_oe && !bus_dout_oe, "R7 hold state floats bus",
              {hold_ack, bus_ctl_oe, bus_dout_oe}, 3'b100);
        req_valid = 1; req_write = 0; req_addr = 23'h0; req_be = 2'b11;
        n = 0;
        repeat (6) begin
            @(negedge clk2);
            if (req_accept) n++;
        end
        check(n == 0, "R7 no accept in hold", n, 0);
        req_valid = 0;
        @(negedge clk2);
        hold_req = 0;
        n = 0;
        do begin @(negedge clk2); n++; end while (hold_ack && n < 10);
        check(n >= 1 && n <= 2, "R7 leaves hold after one state", n, 2);

        // R7 hold taken at end of a cycle
        issue(1, 23'h003000, 2'b11, 16'hC0DE, 3, 0);
        hold_req = 1;
        n = 0;
        while (!rsp_done && n < 40) begin @(negedge clk2); n++; end
        check(hold_ack, "R7 hold entered at acknowledge", hold_ack, 1);
        repeat (4) @(negedge clk2);
        hold_req = 0;
        repeat (4) @(negedge clk2);
        check(!hold_ack, "R7 hold released", hold_ack, 0);

        // R8 early next-address
        issue(0, 23'h005555, 2'b11, 16'h0000, 2, 1);
        drain();
        check(proto_err, "R8 early next-address flagged", proto_err, 1);
        issue(1, 23'h006000, 2'b11, 16'h7777, 0, 0);
        drain();
        check(proto_err, "R8 flag stays set", proto_err, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule